// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions with external Ethernet PHYs over the two-wire management bus: a clock line (MDC) and a bidirectional data line (MDIO). A requester presents a one-cycle request with the direction, a 5-bit PHY address, a register address and 16 bits of write data. The block then generates the whole serial frame. It drives MDC from a divided system clock. It drives or releases MDIO through separate value and output-enable pins. On reads it samples the returning bits. When the frame is finished it pulses `done`, and for a read it presents the 16-bit result.

Every frame opens with a synchronisation run of 33 ones, one more than the 32 the bus needs. After a read command the block releases the line and clocks 19 input bits, keeping only the 16 data bits. After a write it releases the line for two more clocks. A register address that does not fit the 5-bit field is refused without any bus activity. The block runs one transaction at a time and ignores requests while it is busy.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are 0, `mdio_o` is 0, `busy` and `done` are 0 and `rd_data` is 0.
- R2: In each bit slot, `mdc` is low for `HALF_DIV` system clocks and then high for `HALF_DIV` system clocks. The first slot starts in the cycle after the request is accepted. `mdc` stays low whenever `busy` is low. `HALF_DIV` must be chosen so that the MDC rate is no more than 2.5 MHz.
- R3: Every accepted frame opens with 33 slots in which `mdio_oe`=1 and `mdio_o`=1. `mdio_oe` is 1 only while `busy` is high.
- R4: A read then drives 14 slots, MSB first: 0,1 (start), 1,0 (read opcode), the PHY address bits 4..0, then the register address bits 4..0.
- R5: After its command, a read releases MDIO for 19 slots (`mdio_oe`=0, `mdio_o`=0). `mdio_i` is sampled in the last system clock of each low phase. The result is the 3rd through 18th sampled bits, first sampled bit as MSB. It is the 19-bit sample value shifted right by one and masked to 16 bits.
- R6: A write then drives 32 slots, MSB first: 0,1 (start), 0,1 (write opcode), PHY address bits 4..0, register address bits 4..0, 1,0 (turnaround), then write data bits 15..0.
- R7: After its 32 frame slots, a write releases MDIO for 2 more slots (`mdio_oe`=0, `mdio_o`=0).
- R8: `mdio_o` and `mdio_oe` change only in cycles where `mdc` is low. In the cycle `mdc` rises, both hold their previous value.
- R9: A request whose 8-bit `req_reg` exceeds 31 produces no MDC pulse and never enables MDIO. `busy` is high for one cycle and `done` pulses in the next. A refused read returns 0xFFFF. A refused write leaves `rd_data` unchanged.
- R10: `busy` rises in the cycle after acceptance. `done` is a one-cycle pulse in the first cycle `busy` is low again. A read keeps `busy` high for 66 slots and a write for 67 slots. A request presented while `busy` is high is ignored.
- R11: `rd_data` changes only in a `done` cycle, and a completed write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 8 | Register address; values above 31 are refused |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read (0xFFFF if refused) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value |

## Verification
A slot counter that is off by one shows at the ports within a single slot. The command bits on `mdio_o` slide by one position. The release of `mdio_oe` moves. The `done` pulse lands `2*HALF_DIV` cycles early or late. Because the reference model is compared on every system clock, each of these is caught in the first cycle it differs. A divider or phase error shows as a wrong `mdc` level within `HALF_DIV` cycles of acceptance. A sample point in the wrong phase shows up only at the end of a read, as a shifted `rd_data`. The bench's PHY model therefore changes `mdio_i` on each MDC rise, and it sends data patterns that make any one-bit skew visible.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W         = 5;
    localparam int REG_W         = 5;
    localparam int REQ_REG_W     = 8;
    localparam int DATA_W        = 16;
    localparam int FRAME_W       = 32;

    localparam int PRE_SLOTS     = 33;
    localparam int RD_CMD_SLOTS  = 14;
    localparam int RD_IN_SLOTS   = 19;
    localparam int WR_CMD_SLOTS  = FRAME_W;
    localparam int WR_TAIL_SLOTS = 2;

    localparam int RD_SLOTS      = PRE_SLOTS + RD_CMD_SLOTS + RD_IN_SLOTS;
    localparam int WR_SLOTS      = PRE_SLOTS + WR_CMD_SLOTS + WR_TAIL_SLOTS;
    localparam int SLOT_W        = $clog2(WR_SLOTS + 1);

    // input window: two turnaround samples are skipped, then 16 data samples kept
    localparam int RD_IN_FIRST   = PRE_SLOTS + RD_CMD_SLOTS;
    localparam int RD_KEEP_FIRST = RD_IN_FIRST + 2;
    localparam int RD_KEEP_LAST  = RD_KEEP_FIRST + DATA_W - 1;

    localparam logic [DATA_W-1:0] REJECT_DATA = '1;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_REJ  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_t;

    typedef struct packed {
        logic               wr;
        logic [FRAME_W-1:0] frame;
    } xact_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic              wr,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  ra,
        input logic [DATA_W-1:0] d
    );
        if (wr)
            return {2'b01, 2'b01, phy, ra, 2'b10, d};
        return {2'b01, 2'b10, phy, ra, {(FRAME_W - RD_CMD_SLOTS){1'b0}}};
    endfunction

    function automatic slot_t final_slot(input logic wr);
        return wr ? slot_t'(WR_SLOTS - 1) : slot_t'(RD_SLOTS - 1);
    endfunction

    function automatic pin_t slot_drive(input xact_t x, input slot_t s);
        int cmd_len;
        int pos;
        pin_t p;
        cmd_len = x.wr ? WR_CMD_SLOTS : RD_CMD_SLOTS;
        pos     = int'(s) - PRE_SLOTS;
        if (pos < 0) begin
            p.oe  = 1'b1;
            p.val = 1'b1;
        end else if (pos < cmd_len) begin
            p.oe  = 1'b1;
            p.val = x.frame[FRAME_W - 1 - pos];
        end else begin
            p.oe  = 1'b0;
            p.val = 1'b0;
        end
        return p;
    endfunction

    function automatic logic keep_slot(input slot_t s);
        return (s >= slot_t'(RD_KEEP_FIRST)) && (s <= slot_t'(RD_KEEP_LAST));
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic low_last,
    output logic high_last
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign mdc       = phase;
    assign low_last  = run && !phase && (cnt == LAST);
    assign high_last = run &&  phase && (cnt == LAST);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [PHY_W-1:0]      req_phy,
    input  logic [REQ_REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  low_last,
    input  logic                  high_last,
    input  logic [DATA_W-1:0]     cap_data,
    output logic                  run,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  start,
    output logic                  step,
    output logic                  finish,
    output logic                  cap_en,
    output slot_t                 slot_next,
    output xact_t                 xact
);
    seq_state_e state;
    slot_t      slot;
    logic       reg_ok;
    logic       at_last;
    logic       in_run;

    assign reg_ok    = (req_reg < REQ_REG_W'(32));
    assign in_run    = (state == ST_RUN);
    assign at_last   = (slot == final_slot(xact.wr));
    assign run       = in_run;
    assign busy      = (state != ST_IDLE);
    assign start     = (state == ST_IDLE) && req_valid && reg_ok;
    assign step      = in_run && high_last && !at_last;
    assign finish    = in_run && high_last && at_last;
    assign cap_en    = in_run && low_last && !xact.wr && keep_slot(slot);
    assign slot_next = slot + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slot    <= '0;
            xact    <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        xact.wr    <= req_write;
                        xact.frame <= build_frame(req_write, req_phy,
                                                  req_reg[REG_W-1:0], req_wdata);
                        slot       <= '0;
                        state      <= reg_ok ? ST_RUN : ST_REJ;
                    end
                end
                ST_REJ: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    if (!xact.wr)
                        rd_data <= REJECT_DATA;
                end
                ST_RUN: begin
                    if (high_last) begin
                        if (at_last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            if (!xact.wr)
                                rd_data <= cap_data;
                        end else begin
                            slot <= slot_next;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_drv.sv
module mdio_drv
    import mdio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  step,
    input  logic  finish,
    input  slot_t slot_next,
    input  xact_t xact,
    output logic  mdio_o,
    output logic  mdio_oe
);
    pin_t pin;
    pin_t nxt;

    assign nxt = slot_drive(xact, slot_next);

    // updates only on acceptance or at the end of a high phase, so a new bit
    // appears together with the falling MDC edge
    always_ff @(posedge clk) begin
        if (rst || finish) begin
            pin <= '0;
        end else if (start) begin
            pin <= '{oe: 1'b1, val: 1'b1};
        end else if (step) begin
            pin <= nxt;
        end
    end

    assign mdio_o  = pin.val;
    assign mdio_oe = pin.oe;
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic              mdio_i,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            data <= '0;
        else if (en)
            data <= {data[DATA_W-2:0], mdio_i};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [PHY_W-1:0]     req_phy,
    input  logic [REQ_REG_W-1:0] req_reg,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    logic              run;
    logic              low_last;
    logic              high_last;
    logic              start;
    logic              step;
    logic              finish;
    logic              cap_en;
    logic [DATA_W-1:0] cap_data;
    slot_t             slot_next;
    xact_t             xact;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mdc       (mdc),
        .low_last  (low_last),
        .high_last (high_last)
    );

    mdio_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .low_last  (low_last),
        .high_last (high_last),
        .cap_data  (cap_data),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .start     (start),
        .step      (step),
        .finish    (finish),
        .cap_en    (cap_en),
        .slot_next (slot_next),
        .xact      (xact)
    );

    mdio_drv drv_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step      (step),
        .finish    (finish),
        .slot_next (slot_next),
        .xact      (xact),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    mdio_capture cap_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .en     (cap_en),
        .mdio_i (mdio_i),
        .data   (cap_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [REQ_REG_W-1:0] req_reg,
    input logic                 busy,
    input logic                 done,
    input logic [DATA_W-1:0]    rd_data,
    input logic                 mdc,
    input logic                 mdio_o,
    input logic                 mdio_oe
);
    p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_oe_in_xact_r3: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy);

    p_stable_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_change_when_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    p_reject_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && (req_reg > REQ_REG_W'(31)))
            |=> (busy && !mdc && !mdio_oe) ##1 (done && !busy));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_rd_only_at_done_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> done);
endmodule

bind mdio_master mdio_master_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_reg   (req_reg),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int SLOT_CYC   = 2 * HALF;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [7:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;

    // reference model state
    int          m_state = 0;   // 0 idle, 1 running, 2 refused
    int          m_c = 0;
    int          m_n = 0;
    logic        m_wr = 1'b0;
    logic        m_done = 1'b0;
    logic [15:0] m_rd = '0;
    logic [18:0] m_pat = '0;
    logic [1:0]  m_q[$];
    string       m_rdtag = "R1";
    string       m_tag;
    bit          model_on = 1'b0;
    logic [18:0] nx_pat = '0;
    int          slot, ph, jj, kk;
    logic        e_mdc, e_oe, e_o;
    bit          p_valid = 1'b0;
    logic        p_mdc, p_o, p_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) m_q.push_back({1'b1, v[i]});
    endtask

    task automatic build_q(input logic wr, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] d);
        m_q.delete();
        for (int i = 0; i < 33; i++) m_q.push_back(2'b11);
        push_bits(16'b01, 2);
        push_bits(wr ? 16'b01 : 16'b10, 2);
        push_bits({11'd0, phy}, 5);
        push_bits({11'd0, ra}, 5);
        if (wr) begin
            push_bits(16'b10, 2);
            push_bits(d, 16);
            for (int i = 0; i < 2; i++) m_q.push_back(2'b00);
        end else begin
            for (int i = 0; i < 19; i++) m_q.push_back(2'b00);
        end
    endtask

    // cycle model: advances on the state produced by the edge just passed
    always @(negedge clk) begin
        if (rst) begin
            m_state = 0; m_done = 1'b0; m_rd = '0; m_rdtag = "R1";
        end else begin
            m_done = 1'b0;
            case (m_state)
                0: if (req_valid) begin
                    m_wr = req_write;
                    if (req_reg > 8'd31) m_state = 2;
                    else begin
                        m_state = 1; m_c = 0; m_pat = nx_pat;
                        build_q(req_write, req_phy, req_reg[4:0], req_wdata);
                        m_n = m_q.size();
                    end
                end
                2: begin
                    m_state = 0; m_done = 1'b1; m_rdtag = "R9";
                    if (!m_wr) m_rd = 16'hFFFF;
                end
                default: begin
                    m_c++;
                    if (m_c == m_n * SLOT_CYC) begin
                        m_state = 0; m_done = 1'b1;
                        if (!m_wr) begin m_rd = m_pat[16:1]; m_rdtag = "R5"; end
                        else m_rdtag = "R11";
                    end
                end
            endcase
        end

        if (m_state == 1) begin
            slot = m_c / SLOT_CYC; ph = m_c % SLOT_CYC;
            e_mdc = (ph >= HALF);
            {e_oe, e_o} = m_q[slot];
            if (slot < 33) m_tag = "R3";
            else if (m_wr) m_tag = (slot < 65) ? "R6" : "R7";
            else m_tag = (slot < 47) ? "R4" : "R5";
        end else begin
            e_mdc = 1'b0; e_oe = 1'b0; e_o = 1'b0;
            m_tag = (m_state == 2) ? "R9" : "R3";
        end

        if (model_on) begin
            chk("R2", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
            chk(m_tag, "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            chk(m_tag, "mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
            chk("R10", "busy", {31'd0, busy}, {31'd0, (m_state != 0)});
            chk("R10", "done", {31'd0, done}, {31'd0, m_done});
            chk(m_rdtag, "rd_data", {16'd0, rd_data}, {16'd0, m_rd});
            if (p_valid && !p_mdc && mdc)
                chk("R8", "drive at mdc rise", {30'd0, mdio_o, mdio_oe}, {30'd0, p_o, p_oe});
            p_valid = 1'b1; p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
        end

        // PHY model: bit k is presented from the rise that ends slot k-1
        if (m_state == 1 && !m_wr) begin
            jj = (ph < HALF) ? slot : slot + 1;
            kk = jj - 47;
            mdio_i = (kk >= 0 && kk < 19) ? m_pat[18 - kk] : 1'b1;
        end else begin
            mdio_i = 1'b1;
        end
    end

    task automatic do_req(input logic wr, input logic [4:0] phy, input logic [7:0] ra,
                          input logic [15:0] d, input logic [18:0] pat, input int poke);
        @(negedge clk); #1;
        req_write = wr; req_phy = phy; req_reg = ra; req_wdata = d; nx_pat = pat;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (poke > 0) begin
            // R10: a request while busy must be ignored
            repeat (poke) @(negedge clk);
            #1;
            req_write = ~wr; req_phy = 5'h15; req_reg = 8'd7; req_wdata = 16'h0BAD;
            req_valid = 1'b1;
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        tests++; fails++;
        $display("FAIL R10 watchdog: got busy expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        model_on = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset mdc", {31'd0, mdc}, 32'd0);
        chk("R1", "reset mdio_oe", {31'd0, mdio_oe}, 32'd0);
        chk("R1", "reset busy", {31'd0, busy}, 32'd0);
        chk("R1", "reset rd_data", {16'd0, rd_data}, 32'd0);

        // R4 R5: read, turnaround bits 1,0 and idle 1
        do_req(1'b0, 5'h01, 8'd2, 16'h0000, {2'b10, 16'h1234, 1'b1}, 0);
        // R6 R7: write to top addresses, plus an ignored request while busy (R10)
        do_req(1'b1, 5'h1F, 8'd31, 16'hA5C3, 19'h0, 300);
        // R5: alternating edge bits
        do_req(1'b0, 5'h00, 8'd0, 16'h0000, {2'b01, 16'h8001, 1'b0}, 0);
        // R9: refused write keeps rd_data
        do_req(1'b1, 5'h03, 8'h40, 16'hFFFF, 19'h0, 0);
        // R9: refused read returns all ones
        do_req(1'b0, 5'h03, 8'd32, 16'h0000, 19'h0, 0);
        // R5: read after refusal, with a busy-time poke (R10)
        do_req(1'b0, 5'h0A, 8'd21, 16'h0000, {2'b11, 16'h0F5A, 1'b0}, 500);
        // R11: write leaves rd_data alone
        do_req(1'b1, 5'h15, 8'd10, 16'h0001, 19'h0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule